// File: doc/BRIEF.md
# Polygon vertex list fetcher

This block sits between a drawing-command parser and an edge renderer. A command that draws an antialiased polygon outline arrives as a start pulse, together with the byte address of its command word, a vertex count, a winding flag, a link-enable flag, a link-relative flag, a link address and an indication of whether the destination surface uses 16 bits per pixel. The block checks these fields. If they are legal, it walks the vertex words in memory one at a time and presents each vertex to the renderer on a valid/ready stream.

The vertices come from one of two places. Without linking, they follow the command header directly, starting `HDR_WORDS` words after the command word. With linking, they come from a separate region. That region's address is either taken as given (absolute) or added as a signed offset to the command word's address (relative). In the relative case the offset's sign lives in bit `ADDR_W-4`, and the bits above it are copies of that sign. Each vertex word carries X in its low half and Y in its high half. Both are sign-extended to the output coordinate width. The winding flag goes out with every vertex: 1 means clockwise, so the left side of the drawing direction is referenced; 0 means counterclockwise, so the right side is referenced.

An illegal command raises a sticky error and performs no reads. A legal command ends with a one-cycle done pulse after the renderer has taken its last vertex.

Top module: `poly_vtx_fetch`

## Requirements
- R1: With link-enable 0, a legal command's first read address is `cmd_addr_i + 4*HDR_WORDS` (8 by default).
- R2: With link-enable 1 and link-relative 0, the first read address is `link_addr_i` itself.
- R3: With link-enable 1 and link-relative 1, the first read address is the 32-bit two's-complement sum of `cmd_addr_i` and `link_addr_i`. This covers negative offsets.
- R4: A legal command issues exactly n reads at consecutive word addresses (step 4) and emits exactly n vertices. Its read address holds steady while a request waits for acknowledge.
- R5: Each emitted vertex has X = sign-extended bits 15..0 and Y = sign-extended bits 31..16 of the word read for it, at width `COORD_W`.
- R6: `vtx_cw_o` equals the `cw_i` latched at start, for every vertex of that command.
- R7: A vertex count below 2 (0 or 1) sets `err_o` and causes no read and no vertex.
- R8: With `dst16_i` = 0 the command sets `err_o` and causes no read and no vertex.
- R9: With link-enable 1, a bad link address sets `err_o` with no read and no vertex. In absolute mode the address is bad if bits 31..29 or bits 1..0 are nonzero. In relative mode it is bad if bits 31..29 differ from bit 28 or bits 1..0 are nonzero. With link-enable 0 the link address is ignored.
- R10: While `vtx_valid_o` is high and `vtx_ready_i` is low, the vertex outputs stay stable. No read request is issued while a vertex is pending, so at most one word is in flight.
- R11: `vtx_last_o` marks the n-th vertex. `done_o` is high for exactly the one cycle after that vertex is accepted.
- R12: `err_o` stays set until the next start that is accepted while idle, and that start clears it. A `start_i` while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start pulse, taken only when idle |
| cmd_addr_i | input | ADDR_W | Byte address of the command word |
| vcount_i | input | CNT_W | Vertex count n |
| link_en_i | input | 1 | 1: vertices at link address; 0: inline after header |
| link_rel_i | input | 1 | 1: link address is an offset from cmd_addr_i |
| cw_i | input | 1 | Winding: 1 clockwise, 0 counterclockwise |
| dst16_i | input | 1 | Destination is 16 bits per pixel |
| link_addr_i | input | ADDR_W | Link address or offset |
| busy_o | output | 1 | Command in progress |
| err_o | output | 1 | Sticky illegal-command flag |
| done_o | output | 1 | One-cycle pulse after last vertex accepted |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | ADDR_W | Memory read byte address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DATA_W | Read data word |
| vtx_valid_o | output | 1 | Vertex valid |
| vtx_ready_i | input | 1 | Renderer ready |
| vtx_x_o | output | COORD_W | Vertex X, signed |
| vtx_y_o | output | COORD_W | Vertex Y, signed |
| vtx_cw_o | output | 1 | Winding flag for this vertex |
| vtx_last_o | output | 1 | Marks the last vertex of the command |

## Verification
The assertions assume that the memory side raises `rd_ack_i` only while `rd_req_o` is high and never acknowledges more than once per request. They also assume that `start_i` is a single-cycle pulse whose command fields are valid in that cycle. The bench's memory model acknowledges only an outstanding request, after a latency chosen per command, and drops acknowledge on the following half cycle. The renderer model drives ready either constantly high or with a periodic stall pattern. Command fields are set up together with the start pulse and are left alone afterwards, except in the test that deliberately pulses start during a busy command.

// File: rtl/poly_vtx_pkg.sv
package poly_vtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OUT  = 2'd2
  } fetch_st_e;

  localparam int unsigned LINK_HI_BITS = 3;
endpackage

// File: rtl/pvf_link_decode.sv
module pvf_link_decode #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned HDR_WORDS = 2
) (
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [ADDR_W-1:0] link_addr_i,
  input  logic [CNT_W-1:0]  vcount_i,
  input  logic              link_en_i,
  input  logic              link_rel_i,
  input  logic              dst16_i,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic              legal_o
);
  import poly_vtx_pkg::*;

  localparam int unsigned SIGN_BIT = ADDR_W - 1 - LINK_HI_BITS;
  localparam logic [ADDR_W-1:0] HDR_OFS = ADDR_W'(HDR_WORDS * 4);

  logic [LINK_HI_BITS-1:0] hi_bits;
  logic                    low_ok;
  logic                    abs_ok;
  logic                    rel_ok;
  logic                    addr_ok;
  logic                    cnt_ok;

  assign hi_bits = link_addr_i[ADDR_W-1:SIGN_BIT+1];
  assign low_ok  = (link_addr_i[1:0] == 2'b00);
  assign abs_ok  = low_ok && (hi_bits == '0);
  assign rel_ok  = low_ok && (hi_bits == {LINK_HI_BITS{link_addr_i[SIGN_BIT]}});
  assign addr_ok = !link_en_i || (link_rel_i ? rel_ok : abs_ok);
  assign cnt_ok  = (vcount_i >= CNT_W'(2));
  assign legal_o = dst16_i && cnt_ok && addr_ok;

  always_comb begin
    if (!link_en_i)      base_addr_o = cmd_addr_i + HDR_OFS;
    else if (link_rel_i) base_addr_o = cmd_addr_i + link_addr_i;
    else                 base_addr_o = link_addr_i;
  end
endmodule

// File: rtl/pvf_fetch_ctrl.sv
module pvf_fetch_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              legal_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  vcount_i,
  input  logic              cw_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              done_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              vtx_valid_o,
  input  logic              vtx_ready_i,
  output logic [DATA_W-1:0] word_o,
  output logic              cw_o,
  output logic              last_o
);
  import poly_vtx_pkg::*;

  localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(DATA_W / 8);

  fetch_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] word_q;
  logic              cw_q;
  logic              err_q;
  logic              done_q;
  logic              last_w;
  logic              accept_w;

  assign last_w   = (left_q == CNT_W'(1));
  assign accept_w = (st_q == ST_OUT) && vtx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      left_q <= '0;
      word_q <= '0;
      cw_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= accept_w && last_w;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (legal_i) begin
              st_q   <= ST_REQ;
              addr_q <= base_addr_i;
              left_q <= vcount_i;
              cw_q   <= cw_i;
              err_q  <= 1'b0;
            end else begin
              err_q  <= 1'b1;
            end
          end
        end
        ST_REQ: begin
          if (rd_ack_i) begin
            word_q <= rd_data_i;
            st_q   <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (vtx_ready_i) begin
            if (last_w) begin
              st_q <= ST_IDLE;
            end else begin
              left_q <= left_q - CNT_W'(1);
              addr_q <= addr_q + WSTEP;
              st_q   <= ST_REQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign err_o       = err_q;
  assign done_o      = done_q;
  assign rd_req_o    = (st_q == ST_REQ);
  assign rd_addr_o   = addr_q;
  assign vtx_valid_o = (st_q == ST_OUT);
  assign word_o      = word_q;
  assign cw_o        = cw_q;
  assign last_o      = (st_q == ST_OUT) && last_w;

  // R10: pending vertex holds under backpressure
  a_r10_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vtx_valid_o && !vtx_ready_i) |=> (vtx_valid_o && $stable(word_o) && $stable(last_o)));

  // R10: one word in flight
  a_r10_one_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtx_valid_o |-> !rd_req_o);

  // R4: address steady while waiting for acknowledge
  a_r4_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R11: done is a single pulse following the last acceptance
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(vtx_valid_o && vtx_ready_i && last_o));

  // R6: winding fixed for the whole command
  a_r6_cw_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(cw_o)));

  // R7 R12: an error never coexists with a running command
  a_r12_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !rd_req_o && !vtx_valid_o));
endmodule

// File: rtl/pvf_vtx_unpack.sv
module pvf_vtx_unpack #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned COORD_W = 20
) (
  input  logic [DATA_W-1:0]  word_i,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] x_raw;
  logic [HALF_W-1:0] y_raw;

  assign x_raw = word_i[HALF_W-1:0];
  assign y_raw = word_i[DATA_W-1:HALF_W];

  generate
    if (COORD_W > HALF_W) begin : g_ext
      assign x_o = {{(COORD_W-HALF_W){x_raw[HALF_W-1]}}, x_raw};
      assign y_o = {{(COORD_W-HALF_W){y_raw[HALF_W-1]}}, y_raw};
    end else begin : g_trunc
      assign x_o = x_raw[COORD_W-1:0];
      assign y_o = y_raw[COORD_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/poly_vtx_fetch.sv
module poly_vtx_fetch #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned COORD_W   = 20,
  parameter int unsigned HDR_WORDS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [CNT_W-1:0]   vcount_i,
  input  logic               link_en_i,
  input  logic               link_rel_i,
  input  logic               cw_i,
  input  logic               dst16_i,
  input  logic [ADDR_W-1:0]  link_addr_i,
  output logic               busy_o,
  output logic               err_o,
  output logic               done_o,
  output logic               rd_req_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic               rd_ack_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               vtx_valid_o,
  input  logic               vtx_ready_i,
  output logic [COORD_W-1:0] vtx_x_o,
  output logic [COORD_W-1:0] vtx_y_o,
  output logic               vtx_cw_o,
  output logic               vtx_last_o
);
  logic [ADDR_W-1:0] base_addr;
  logic              legal;
  logic [DATA_W-1:0] word;

  pvf_link_decode #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HDR_WORDS(HDR_WORDS)
  ) u_dec (
    .cmd_addr_i (cmd_addr_i),
    .link_addr_i(link_addr_i),
    .vcount_i   (vcount_i),
    .link_en_i  (link_en_i),
    .link_rel_i (link_rel_i),
    .dst16_i    (dst16_i),
    .base_addr_o(base_addr),
    .legal_o    (legal)
  );

  pvf_fetch_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .legal_i    (legal),
    .base_addr_i(base_addr),
    .vcount_i   (vcount_i),
    .cw_i       (cw_i),
    .busy_o     (busy_o),
    .err_o      (err_o),
    .done_o     (done_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ack_i   (rd_ack_i),
    .rd_data_i  (rd_data_i),
    .vtx_valid_o(vtx_valid_o),
    .vtx_ready_i(vtx_ready_i),
    .word_o     (word),
    .cw_o       (vtx_cw_o),
    .last_o     (vtx_last_o)
  );

  pvf_vtx_unpack #(
    .DATA_W(DATA_W), .COORD_W(COORD_W)
  ) u_unpack (
    .word_i(word),
    .x_o   (vtx_x_o),
    .y_o   (vtx_y_o)
  );

  // R7 R8 R9: a rejected start leaves the read port idle next cycle
  a_r9_reject_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !legal) |=> (!rd_req_o && err_o));

  // R1 R2 R3: an accepted start begins reading at the decoded base
  a_r1_first_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && legal) |=> (rd_req_o && rd_addr_o == $past(base_addr)));
endmodule

// File: tb/poly_vtx_fetch_test.sv
module poly_vtx_fetch_test;
  localparam int CLK_PERIOD = 10;
  localparam int COORD_W = 20;
  localparam int NV = 13;

  typedef struct packed {
    logic [31:0] cmd;
    logic [15:0] n;
    logic        le;
    logic        lr;
    logic        cw;
    logic        d16;
    logic [31:0] link;
    logic        xerr;
    logic [31:0] xbase;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 16'd3, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,         1'b0, 32'h0000_1008, 4'd1}, // R1 inline
    '{32'h0000_2000, 16'd4, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0004_0000, 1'b0, 32'h0004_0000, 4'd2}, // R2 absolute
    '{32'h0001_0000, 16'd2, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0100, 1'b0, 32'h0001_0100, 4'd3}, // R3 positive
    '{32'h0001_0000, 16'd3, 1'b1, 1'b1, 1'b0, 1'b1, 32'hFFFF_FF00, 1'b0, 32'h0000_FF00, 4'd3}, // R3 negative
    '{32'h0000_3000, 16'd1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,         1'b1, 32'h0,         4'd7}, // R7 n=1
    '{32'h0000_3000, 16'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,         1'b1, 32'h0,         4'd7}, // R7 n=0
    '{32'h0000_3000, 16'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         1'b1, 32'h0,         4'd8}, // R8 not 16bpp
    '{32'h0000_3000, 16'd3, 1'b1, 1'b0, 1'b1, 1'b1, 32'h2000_0000, 1'b1, 32'h0,         4'd9}, // R9 abs high bit
    '{32'h0000_3000, 16'd3, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0004_0002, 1'b1, 32'h0,         4'd9}, // R9 abs low bit
    '{32'h0000_3000, 16'd3, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1000_0000, 1'b1, 32'h0,         4'd9}, // R9 rel sign mismatch
    '{32'h0000_3000, 16'd3, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0101, 1'b1, 32'h0,         4'd9}, // R9 rel low bit
    '{32'h0000_4000, 16'd2, 1'b0, 1'b1, 1'b0, 1'b1, 32'hE000_0003, 1'b0, 32'h0000_4008, 4'd9}, // R9 link ignored inline
    '{32'h0000_5000, 16'd5, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,         1'b0, 32'h0000_5008, 4'd1}  // R1 longer run
  };

  logic               clk;
  logic               rst_n;
  logic               start;
  logic [31:0]        cmd_addr;
  logic [15:0]        vcount;
  logic               link_en;
  logic               link_rel;
  logic               cw;
  logic               dst16;
  logic [31:0]        link_addr;
  logic               busy;
  logic               err;
  logic               done;
  logic               rd_req;
  logic [31:0]        rd_addr;
  logic               rd_ack;
  logic [31:0]        rd_data;
  logic               vtx_valid;
  logic               vtx_ready;
  logic [COORD_W-1:0] vtx_x;
  logic [COORD_W-1:0] vtx_y;
  logic               vtx_cw;
  logic               vtx_last;

  poly_vtx_fetch #(.COORD_W(COORD_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_addr_i(cmd_addr),
    .vcount_i(vcount), .link_en_i(link_en), .link_rel_i(link_rel), .cw_i(cw),
    .dst16_i(dst16), .link_addr_i(link_addr), .busy_o(busy), .err_o(err),
    .done_o(done), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack),
    .rd_data_i(rd_data), .vtx_valid_o(vtx_valid), .vtx_ready_i(vtx_ready),
    .vtx_x_o(vtx_x), .vtx_y_o(vtx_y), .vtx_cw_o(vtx_cw), .vtx_last_o(vtx_last)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] cur_base;
  int          cur_n;
  logic        cur_cw;
  bit          stall_mode;
  int          mem_lat;
  int          lat_cnt;
  int          rd_cnt, vcnt, done_cnt;
  logic [31:0] first_addr;
  int          mism_addr, mism_xy, mism_cw, mism_last, mism_hold, mism_done;
  bit          last_pend, prev_stall;
  logic [COORD_W-1:0] hold_x, hold_y;
  logic        hold_last;
  int          cyc = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[17:2] ^ 16'hC3A5, a[15:0] ^ 16'h9E37};
  endfunction

  function automatic logic [COORD_W-1:0] sx(input logic [15:0] h);
    return {{(COORD_W-16){h[15]}}, h};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory and renderer models
  always @(negedge clk) begin
    cyc++;
    vtx_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
    if (last_pend) begin
      if (!done) mism_done++;
      last_pend = 0;
    end
    if (done) done_cnt++;
    if (prev_stall) begin
      if (!vtx_valid || vtx_x != hold_x || vtx_y != hold_y || vtx_last != hold_last) mism_hold++;
    end
    prev_stall = vtx_valid && !vtx_ready;
    hold_x = vtx_x; hold_y = vtx_y; hold_last = vtx_last;
    if (vtx_valid && vtx_ready) begin
      logic [31:0] w;
      w = mem_word(cur_base + 32'(4 * vcnt));
      if (vtx_x != sx(w[15:0]) || vtx_y != sx(w[31:16])) mism_xy++;
      if (vtx_cw != cur_cw) mism_cw++;
      if (vtx_last != (vcnt == cur_n - 1)) mism_last++;
      if (vtx_last) last_pend = 1;
      vcnt++;
    end
    if (rd_ack) begin
      rd_ack = 1'b0;
      lat_cnt = 0;
    end else if (rd_req) begin
      if (lat_cnt >= mem_lat) begin
        rd_ack  = 1'b1;
        rd_data = mem_word(rd_addr);
        if (rd_cnt == 0) first_addr = rd_addr;
        if (rd_addr != cur_base + 32'(4 * rd_cnt)) mism_addr++;
        rd_cnt++;
        lat_cnt = 0;
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic clear_mon(input vec_t v, input bit stl, input int lat);
    cur_base = v.xbase; cur_n = int'(v.n); cur_cw = v.cw;
    stall_mode = stl; mem_lat = lat;
    rd_cnt = 0; vcnt = 0; done_cnt = 0; first_addr = 32'h0;
    mism_addr = 0; mism_xy = 0; mism_cw = 0; mism_last = 0; mism_hold = 0; mism_done = 0;
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    cmd_addr = v.cmd; vcount = v.n; link_en = v.le; link_rel = v.lr;
    cw = v.cw; dst16 = v.d16; link_addr = v.link; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_run(input vec_t v, input bit stl);
    string tg;
    tg = $sformatf("R%0d", v.req);
    check(err == v.xerr, tg, 64'(err), 64'(v.xerr));
    if (v.xerr) begin
      check(rd_cnt == 0 && vcnt == 0, tg, 64'(rd_cnt + vcnt), 64'd0);
    end else begin
      check(first_addr == v.xbase, tg, 64'(first_addr), 64'(v.xbase));           // R1 R2 R3
      check(rd_cnt == cur_n && vcnt == cur_n && mism_addr == 0, "R4",
            64'(vcnt), 64'(cur_n));
      check(mism_xy == 0, "R5", 64'(mism_xy), 64'd0);
      check(mism_cw == 0, "R6", 64'(mism_cw), 64'd0);
      check(mism_last == 0 && mism_done == 0 && done_cnt == 1, "R11",
            64'(done_cnt), 64'd1);
      if (stl) check(mism_hold == 0, "R10", 64'(mism_hold), 64'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_addr = '0; vcount = '0; link_en = 1'b0;
    link_rel = 1'b0; cw = 1'b0; dst16 = 1'b0; link_addr = '0;
    rd_ack = 1'b0; rd_data = '0; vtx_ready = 1'b1;
    stall_mode = 0; mem_lat = 0; lat_cnt = 0; last_pend = 0; prev_stall = 0;
    clear_mon(VECS[0], 0, 0);
    repeat (3) @(negedge clk);
    check(!busy && !err && !done && !rd_req && !vtx_valid, "reset",
          64'({busy, err, done, rd_req, vtx_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      clear_mon(VECS[i], i[0], i % 3);
      launch(VECS[i]);
      wait_idle();
      check_run(VECS[i], i[0]);
    end

    // R12: start while busy is ignored
    clear_mon(VECS[0], 1, 2);
    launch(VECS[0]);
    @(negedge clk);
    cmd_addr = 32'h0000_9000; vcount = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check(first_addr == 32'h0000_1008 && vcnt == 3 && rd_cnt == 3 && mism_addr == 0,
          "R12", 64'(vcnt), 64'd3);

    // R12: error is sticky until an accepted start clears it
    clear_mon(VECS[4], 0, 0);
    launch(VECS[4]);
    repeat (6) @(negedge clk);
    check(err == 1'b1, "R12", 64'(err), 64'd1);
    clear_mon(VECS[2], 0, 1);
    launch(VECS[2]);
    check(err == 1'b0 && busy == 1'b1, "R12", 64'({err, busy}), 64'b01);
    wait_idle();
    check_run(VECS[2], 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule